// File: doc/BRIEF.md
# Cross-Domain Bus Slave Wrapper

This block is the bus-side front end of a peripheral that runs on its own clock, unrelated to the system bus clock. It answers single AHB transfers and splits its address window into up to four equal quarters. Each populated quarter is a sub-slave. The bus master never sees the sub-slaves: it only sees one slave with one flat word window.

An accepted transfer is held for a fixed number of wait states. During that time a toggle request crosses into the peripheral clock through a three-stage synchronizer. On the far side it becomes a chip-select pulse of preset width on the addressed sub-slave's line.

The frozen address, the direction and the captured write data are held on the bus side for the whole transfer. They are read in the peripheral domain as multicycle paths. Read data is captured in a holding register in the peripheral domain. It is then loaded into the bus read-data register one cycle before the transfer completes. No handshake returns from the peripheral. Correct operation relies on the wait counts being long enough for the two clock rates in use.

Top module: `xdw_slave_wrap`

## Requirements
- R1: After reset, hreadyout is 1, hresp is 0, hrdata is 0 and no per_cs bit is set.
- R2: A transfer is accepted only when hsel is 1, htrans is NONSEQ (2) or SEQ (3) and hready_in is 1. With IDLE (0), BUSY (1) or hsel low, hreadyout stays 1 on the next cycle and no chip-select pulse follows.
- R3: An accepted read holds hreadyout low for exactly RD_WAIT cycles of its data phase. The next cycle has hreadyout high and completes the read.
- R4: An accepted write holds hreadyout low for exactly WR_WAIT cycles of its data phase.
- R5: The sub-slave index is the top two bits of the word address, haddr[AW-1:AW-2] with AW = log2(WORDS)+2. A transfer to index k < NSUB gives exactly one pulse on per_cs[k]. During that pulse, per_addr is haddr[AW-3:2] and per_wr is hwrite. For a write, per_wdata is the hwdata of the data phase.
- R6: Each chip-select pulse lasts exactly CS_W peripheral clock cycles, and at most one per_cs bit is high at any time.
- R7: A read to a populated sub-slave returns on hrdata, in its completing cycle, the per_rdata slice [32k+31:32k] that the sub-slave presented for per_addr.
- R8: A transfer whose index is NSUB or higher raises no chip-select. A read of it returns SLAVE_ID, and a write to it changes no sub-slave.
- R9: hresp is 0 (OKAY) on every cycle.
- R10: per_addr and per_wr stay stable while hreadyout is low. per_addr and per_wdata stay stable while a chip-select pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Bus-domain reset, active low |
| hsel | input | 1 | Slave select from the address decoder |
| haddr | input | AW | Byte address within the slave window |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 for write, 0 for read |
| hwdata | input | 32 | Write data, valid in the data phase |
| hready_in | input | 1 | Bus-wide ready (previous transfer done) |
| hreadyout | output | 1 | This slave's ready, low during wait states |
| hresp | output | 1 | Response, always OKAY |
| hrdata | output | 32 | Read data |
| pclk | input | 1 | Peripheral clock |
| presetn | input | 1 | Peripheral-domain reset, active low |
| per_cs | output | NSUB | One-hot chip-select pulses, one per sub-slave |
| per_addr | output | AW-4 | Word offset within the sub-slave |
| per_wr | output | 1 | Direction of the current transfer |
| per_wdata | output | 32 | Write data held for the peripheral |
| per_rdata | input | 32*NSUB | Read data of every sub-slave, slice k for sub-slave k |

## Verification
The hardest situation to reach from the ports is a new transfer accepted in the very cycle the previous one completes. The new address overwrites the frozen register while the previous read data has only just been taken over from the other clock domain. The stimulus reaches it by issuing transfers back to back. Each address phase is driven in the completing cycle of the one before, so the chip-select pulses of consecutive transfers follow each other as closely as the wait counts allow.

A peripheral clock period that does not divide the bus period shifts the synchronizer's arrival point from one transfer to the next. Writes to the unpopulated quarter are followed by read-back of every populated quarter. This shows that a write there changed none of them.

// File: rtl/xdw_pkg.sv
// Shared definitions for the cross-domain slave wrapper.
// Assumes: single (non-burst) AHB transfers; 32-bit data.
package xdw_pkg;
    localparam int DW      = 32;
    localparam int SUB_MAX = 4;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'd0,
        TR_BUSY   = 2'd1,
        TR_NONSEQ = 2'd2,
        TR_SEQ    = 2'd3
    } trans_e;
endpackage

// File: rtl/xdw_sync.sv
// Multi-stage single-bit synchronizer into the destination clock.
// Assumes: input is a level that changes at most once per several cycles.
module xdw_sync #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/xdw_bus_ctrl.sv
// Bus-clock side: accepts transfers, freezes address and direction,
// captures write data, counts wait states, toggles the cross request,
// and loads the read-data register one cycle before completion.
// Assumes: the wait counts cover synchronizer and pulse latency.
module xdw_bus_ctrl
    import xdw_pkg::*;
#(
    parameter int          WA       = 6,
    parameter int          NSUB     = 3,
    parameter int          RD_WAIT  = 14,
    parameter int          WR_WAIT  = 14,
    parameter logic [31:0] SLAVE_ID = 32'h5A1D_0003
) (
    input  logic          hclk,
    input  logic          hresetn,
    input  logic          hsel,
    input  logic [WA-1:0] word_addr,
    input  logic          trans_act,
    input  logic          hwrite,
    input  logic [DW-1:0] hwdata,
    input  logic          hready_in,
    input  logic [DW-1:0] rd_hold,
    output logic          hreadyout,
    output logic [DW-1:0] hrdata,
    output logic [WA-1:0] addr_q,
    output logic          wr_q,
    output logic [DW-1:0] wdata_q,
    output logic          req_tgl
);
    localparam int MAXW  = (RD_WAIT > WR_WAIT) ? RD_WAIT : WR_WAIT;
    localparam int CNT_W = $clog2(MAXW + 1);

    logic             busy;
    logic             first;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       sub_idx;
    logic             sub_ok;
    logic             accept;

    assign sub_idx   = addr_q[WA-1 -: 2];
    assign sub_ok    = ({30'd0, sub_idx} < NSUB);
    assign accept    = hsel && trans_act && hready_in;
    assign hreadyout = !busy || (cnt == '0);

    // Transfer sequencing: accept, count down waits, capture data.
    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) begin
            busy    <= 1'b0;
            first   <= 1'b0;
            cnt     <= '0;
            addr_q  <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            req_tgl <= 1'b0;
            hrdata  <= '0;
        end else if (busy && cnt != '0) begin
            cnt   <= cnt - CNT_W'(1);
            first <= 1'b0;
            if (first) begin
                if (wr_q)   wdata_q <= hwdata;
                if (sub_ok) req_tgl <= ~req_tgl;
            end
            if (cnt == CNT_W'(1) && !wr_q)
                hrdata <= sub_ok ? rd_hold : SLAVE_ID;
        end else begin
            busy  <= accept;
            first <= accept;
            if (accept) begin
                addr_q <= word_addr;
                wr_q   <= hwrite;
                cnt    <= hwrite ? CNT_W'(WR_WAIT) : CNT_W'(RD_WAIT);
            end
        end
    end
endmodule

// File: rtl/xdw_per_side.sv
// Peripheral-clock side: detects the synchronized request toggle,
// forms a chip-select pulse of CS_W cycles on the addressed sub-slave
// and captures that sub-slave's read data into a holding register.
// Assumes: addr_q and wr_q are stable (multicycle) while a pulse runs.
module xdw_per_side
    import xdw_pkg::*;
#(
    parameter int WA   = 6,
    parameter int NSUB = 3,
    parameter int SYNC = 3,
    parameter int CS_W = 2
) (
    input  logic               pclk,
    input  logic               presetn,
    input  logic               req_tgl,
    input  logic [WA-1:0]      addr_q,
    input  logic               wr_q,
    input  logic [NSUB*DW-1:0] per_rdata,
    output logic [NSUB-1:0]    per_cs,
    output logic [DW-1:0]      rd_hold
);
    localparam int PW = $clog2(CS_W + 1);

    logic          tgl_s;
    logic          tgl_d;
    logic          evt;
    logic [PW-1:0] pcnt;
    logic [PW-1:0] pcnt_nxt;
    logic [1:0]    sub_idx;
    logic [DW-1:0] rd_sel;

    xdw_sync #(.STAGES(SYNC)) u_sync (
        .clk   (pclk),
        .rst_n (presetn),
        .d     (req_tgl),
        .q     (tgl_s)
    );

    assign evt     = tgl_s ^ tgl_d;
    assign sub_idx = addr_q[WA-1 -: 2];

    // Remaining pulse length after this edge.
    always_comb begin
        if (evt)              pcnt_nxt = PW'(CS_W);
        else if (pcnt != '0)  pcnt_nxt = pcnt - PW'(1);
        else                  pcnt_nxt = '0;
    end

    // Select the addressed sub-slave's read data.
    always_comb begin
        rd_sel = '0;
        for (int k = 0; k < NSUB; k++)
            if (sub_idx == 2'(k)) rd_sel = per_rdata[k*DW +: DW];
    end

    // Edge detect, pulse counter and read-data capture.
    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            tgl_d   <= 1'b0;
            pcnt    <= '0;
            rd_hold <= '0;
        end else begin
            tgl_d <= tgl_s;
            pcnt  <= pcnt_nxt;
            if ((|per_cs) && !wr_q) rd_hold <= rd_sel;
        end
    end

    // One registered chip-select line per populated sub-slave.
    for (genvar g = 0; g < NSUB; g++) begin : g_cs
        always_ff @(posedge pclk or negedge presetn) begin
            if (!presetn) per_cs[g] <= 1'b0;
            else          per_cs[g] <= (pcnt_nxt != '0) && (sub_idx == 2'(g));
        end
    end
endmodule

// File: rtl/xdw_slave_wrap.sv
// Top of the cross-domain slave wrapper: bus-side control, peripheral-
// side pulse logic, and the handshake-free crossing between them.
// Assumes: one slave on the bus segment; wait counts sized for the
// ratio of the two clocks; peripheral read data is combinational.
module xdw_slave_wrap
    import xdw_pkg::*;
#(
    parameter int          NSUB     = 3,
    parameter int          WORDS    = 64,
    parameter int          RD_WAIT  = 14,
    parameter int          WR_WAIT  = 14,
    parameter int          CS_W     = 2,
    parameter int          SYNC     = 3,
    parameter logic [31:0] SLAVE_ID = 32'h5A1D_0003,
    localparam int         WA       = $clog2(WORDS),
    localparam int         AW       = WA + 2
) (
    input  logic               hclk,
    input  logic               hresetn,
    input  logic               hsel,
    input  logic [AW-1:0]      haddr,
    input  logic [1:0]         htrans,
    input  logic               hwrite,
    input  logic [31:0]        hwdata,
    input  logic               hready_in,
    output logic               hreadyout,
    output logic               hresp,
    output logic [31:0]        hrdata,
    input  logic               pclk,
    input  logic               presetn,
    output logic [NSUB-1:0]    per_cs,
    output logic [WA-3:0]      per_addr,
    output logic               per_wr,
    output logic [31:0]        per_wdata,
    input  logic [NSUB*32-1:0] per_rdata
);
    logic [WA-1:0] addr_q;
    logic          req_tgl;
    logic [DW-1:0] rd_hold;
    logic          unused_bits;

    assign unused_bits = ^{haddr[1:0], htrans[0]};
    assign hresp       = 1'b0;
    assign per_addr    = addr_q[WA-3:0];

    xdw_bus_ctrl #(
        .WA(WA), .NSUB(NSUB), .RD_WAIT(RD_WAIT), .WR_WAIT(WR_WAIT),
        .SLAVE_ID(SLAVE_ID)
    ) u_bus (
        .hclk      (hclk),
        .hresetn   (hresetn),
        .hsel      (hsel),
        .word_addr (haddr[AW-1:2]),
        .trans_act (htrans[1]),
        .hwrite    (hwrite),
        .hwdata    (hwdata),
        .hready_in (hready_in),
        .rd_hold   (rd_hold),
        .hreadyout (hreadyout),
        .hrdata    (hrdata),
        .addr_q    (addr_q),
        .wr_q      (per_wr),
        .wdata_q   (per_wdata),
        .req_tgl   (req_tgl)
    );

    xdw_per_side #(
        .WA(WA), .NSUB(NSUB), .SYNC(SYNC), .CS_W(CS_W)
    ) u_per (
        .pclk      (pclk),
        .presetn   (presetn),
        .req_tgl   (req_tgl),
        .addr_q    (addr_q),
        .wr_q      (per_wr),
        .per_rdata (per_rdata),
        .per_cs    (per_cs),
        .rd_hold   (rd_hold)
    );
endmodule

// File: rtl/xdw_chk.sv
// Assertion checker for xdw_slave_wrap, observing its ports only.
// Assumes: single-slave segment (hready_in follows hreadyout).
module xdw_chk #(
    parameter int NSUB    = 3,
    parameter int WORDS   = 64,
    parameter int RD_WAIT = 14,
    parameter int WR_WAIT = 14,
    parameter int CS_W    = 2,
    parameter int SYNC    = 3,
    localparam int WA     = $clog2(WORDS),
    localparam int AW     = WA + 2
) (
    input logic               hclk,
    input logic               hresetn,
    input logic               hsel,
    input logic [AW-1:0]      haddr,
    input logic [1:0]         htrans,
    input logic               hwrite,
    input logic [31:0]        hwdata,
    input logic               hready_in,
    input logic               hreadyout,
    input logic               hresp,
    input logic [31:0]        hrdata,
    input logic               pclk,
    input logic               presetn,
    input logic [NSUB-1:0]    per_cs,
    input logic [WA-3:0]      per_addr,
    input logic               per_wr,
    input logic [31:0]        per_wdata,
    input logic [NSUB*32-1:0] per_rdata
);
    localparam int MIN_WAIT = SYNC + CS_W + 2;

    if (RD_WAIT < MIN_WAIT || WR_WAIT < MIN_WAIT) begin : g_bad_wait
        $error("wait-state count below crossing latency");
    end

    logic       unused_chk;
    logic [7:0] low_cnt;
    logic       rec_wr;
    logic [7:0] pw_cnt;

    assign unused_chk = ^{haddr, hwdata, hresp, hrdata, per_rdata};

    // Count wait cycles of the current data phase and note its direction.
    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) begin
            low_cnt <= '0;
            rec_wr  <= 1'b0;
        end else begin
            low_cnt <= hreadyout ? 8'd0 : low_cnt + 8'd1;
            if (hreadyout && hsel && htrans[1] && hready_in) rec_wr <= hwrite;
        end
    end

    // Measure the length of each chip-select pulse.
    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) pw_cnt <= '0;
        else          pw_cnt <= (|per_cs) ? pw_cnt + 8'd1 : 8'd0;
    end

    // R2
    idle_no_wait_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        (hreadyout && hready_in && !(hsel && htrans[1])) |=> hreadyout);

    // R3 R4
    wait_len_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        (hreadyout && low_cnt != 8'd0) |->
            (low_cnt == (rec_wr ? 8'(WR_WAIT) : 8'(RD_WAIT))));

    // R10
    frozen_addr_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        !hreadyout |=> ($stable(per_addr) && $stable(per_wr)));

    // R6
    cs_onehot_chk: assert property (@(posedge pclk) disable iff (!presetn)
        $onehot0(per_cs));

    // R6
    cs_width_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (!(|per_cs) && pw_cnt != 8'd0) |-> (pw_cnt == 8'(CS_W)));

    // R10
    cs_data_stable_chk: assert property (@(posedge pclk) disable iff (!presetn)
        ((|per_cs) && pw_cnt != 8'd0) |-> ($stable(per_wdata) && $stable(per_addr)));
endmodule

bind xdw_slave_wrap xdw_chk #(
    .NSUB(NSUB), .WORDS(WORDS), .RD_WAIT(RD_WAIT), .WR_WAIT(WR_WAIT),
    .CS_W(CS_W), .SYNC(SYNC)
) u_chk (.*);

// File: tb/test_xdw_slave_wrap.sv
`timescale 1ns/1ps
module test_xdw_slave_wrap;
    localparam int          NSUB = 3;
    localparam int          WORDS = 64;
    localparam int          RDW = 14;
    localparam int          WRW = 14;
    localparam int          CSW = 2;
    localparam logic [31:0] SID = 32'h5A1D_0003;
    localparam int          AW = 8;

    logic hclk = 0, pclk = 0, hresetn = 0, presetn = 0;
    logic hsel = 0, hwrite = 0;
    logic [AW-1:0] haddr = '0;
    logic [1:0] htrans = 2'd0;
    logic [31:0] hwdata = '0;
    logic hreadyout, hresp;
    logic [31:0] hrdata, per_wdata;
    logic [NSUB-1:0] per_cs;
    logic [3:0] per_addr;
    logic per_wr;
    logic [NSUB*32-1:0] per_rdata;

    int checks = 0, errors = 0;

    always #2.5  hclk = ~hclk;
    always #3.65 pclk = ~pclk;

    xdw_slave_wrap #(.NSUB(NSUB), .WORDS(WORDS), .RD_WAIT(RDW), .WR_WAIT(WRW),
                     .CS_W(CSW), .SLAVE_ID(SID)) i_xdw_slave_wrap (
        .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr),
        .htrans(htrans), .hwrite(hwrite), .hwdata(hwdata),
        .hready_in(hreadyout), .hreadyout(hreadyout), .hresp(hresp),
        .hrdata(hrdata), .pclk(pclk), .presetn(presetn), .per_cs(per_cs),
        .per_addr(per_addr), .per_wr(per_wr), .per_wdata(per_wdata),
        .per_rdata(per_rdata));

    // Behavioural sub-slaves: 16 words each, written on chip-select.
    logic [31:0] mem [0:NSUB-1][0:15];
    logic [31:0] shadow [0:3][0:15];
    always @(posedge pclk)
        for (int i = 0; i < NSUB; i++)
            if (per_cs[i] && per_wr) mem[i][per_addr] <= per_wdata;
    for (genvar g = 0; g < NSUB; g++) begin : g_rd
        assign per_rdata[g*32 +: 32] = mem[g][per_addr];
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Pulse monitor in the peripheral domain.
    int q_idx[$], q_addr[$], q_wr[$], q_w[$];
    logic [31:0] q_data[$];
    int cur_w = 0;
    always @(negedge pclk) begin
        if (|per_cs) begin
            if (cur_w == 0)
                for (int i = 0; i < NSUB; i++)
                    if (per_cs[i]) begin
                        q_idx.push_back(i); q_addr.push_back(int'(per_addr));
                        q_wr.push_back(int'(per_wr)); q_data.push_back(per_wdata);
                    end
            cur_w++;
        end else if (cur_w != 0) begin
            q_w.push_back(cur_w);
            cur_w = 0;
        end
    end

    // Cycle-by-cycle reference of hreadyout and hresp.
    bit m_busy = 0;
    int m_left = 0;
    always @(posedge hclk) begin
        if (!hresetn) begin
            m_busy = 0; m_left = 0;
        end else if (m_busy && m_left > 0) begin
            m_left--;
        end else begin
            m_busy = hsel && htrans[1];
            if (m_busy) m_left = hwrite ? WRW : RDW;
        end
    end
    always @(negedge hclk) if (hresetn) begin
        check(hreadyout == (!m_busy || m_left == 0), "R2 R3 R4 hreadyout",
              hreadyout, (!m_busy || m_left == 0));
        check(hresp == 1'b0, "R9 hresp", hresp, 0);
    end

    // One single transfer, starting just after a falling hclk edge.
    task automatic xfer(input bit wr, input int sub, input int off,
                        input logic [31:0] wd, output logic [31:0] rd);
        int waits = 0;
        hsel = 1; htrans = 2'd2; hwrite = wr;
        haddr = {sub[1:0], off[3:0], 2'b00};
        @(posedge hclk);
        @(negedge hclk);
        hsel = 0; htrans = 2'd0; hwdata = wd;
        while (!hreadyout) begin waits++; @(negedge hclk); end
        rd = hrdata;
        if (wr) check(waits == WRW, "R4 write waits", waits, WRW);
        else    check(waits == RDW, "R3 read waits", waits, RDW);
        if (sub < NSUB) begin
            check(q_idx.size() == 1 && q_w.size() == 1, "R5 one pulse", q_idx.size(), 1);
            if (q_idx.size() == 1 && q_w.size() == 1) begin
                check(q_idx[0] == sub, "R5 sub index", q_idx[0], sub);
                check(q_addr[0] == off, "R5 offset", q_addr[0], off);
                check(q_wr[0] == int'(wr), "R5 direction", q_wr[0], wr);
                if (wr) check(q_data[0] == wd, "R5 write data", q_data[0], wd);
                check(q_w[0] == CSW, "R6 pulse width", q_w[0], CSW);
            end
        end else begin
            check(q_idx.size() == 0, "R8 no pulse", q_idx.size(), 0);
        end
        q_idx.delete(); q_addr.delete(); q_wr.delete(); q_data.delete(); q_w.delete();
        if (wr && sub < NSUB) shadow[sub][off] = wd;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        for (int s = 0; s < NSUB; s++)
            for (int o = 0; o < 16; o++) mem[s][o] = 32'h0;
        for (int s = 0; s < 4; s++)
            for (int o = 0; o < 16; o++) shadow[s][o] = 32'h0;
        repeat (5) @(negedge hclk);
        hresetn = 1; presetn = 1;
        @(negedge hclk);
        // R1 reset state
        check(hreadyout == 1'b1, "R1 hreadyout", hreadyout, 1);
        check(hrdata == 32'h0, "R1 hrdata", hrdata, 0);
        check(per_cs == '0, "R1 per_cs", per_cs, 0);
        check(hresp == 1'b0, "R1 hresp", hresp, 0);

        // R2: IDLE, BUSY, and NONSEQ without hsel start nothing.
        hsel = 1; htrans = 2'd0; hwrite = 1; repeat (6) @(negedge hclk);
        htrans = 2'd1; repeat (6) @(negedge hclk);
        hsel = 0; htrans = 2'd2; repeat (6) @(negedge hclk);
        htrans = 2'd0;
        repeat (10) @(negedge hclk);
        check(q_idx.size() == 0, "R2 no pulse on idle", q_idx.size(), 0);
        check(hreadyout == 1'b1, "R2 ready after idle", hreadyout, 1);

        // Write patterns then read back every sub-slave (R5 R7).
        for (int s = 0; s < NSUB; s++) begin
            xfer(1, s, 0,  32'hA000_0000 | (s << 8), rd);
            xfer(1, s, 15, 32'h5555_AAAA ^ s, rd);
            xfer(1, s, 5,  ~(32'h0000_1234 + s), rd);
        end
        // Write to the unpopulated quarter (R8).
        xfer(1, 3, 5, 32'hFFFF_FFFF, rd);
        xfer(1, 3, 0, 32'h1234_5678, rd);
        for (int s = 0; s < NSUB; s++)
            foreach (shadow[0][o]) begin
                hwdata = 32'hDEAD_BEEF;
                xfer(0, s, o, 32'hDEAD_BEEF, rd);
                check(rd == shadow[s][o], "R7 read back", rd, shadow[s][o]);
            end
        // R8 reads of the unpopulated quarter give the slave ID.
        xfer(0, 3, 5, 32'h0, rd);
        check(rd == SID, "R8 slave id", rd, SID);
        xfer(0, 3, 0, 32'h0, rd);
        check(rd == SID, "R8 slave id", rd, SID);
        // Alternating back-to-back write/read on different sub-slaves.
        for (int k = 0; k < 8; k++) begin
            xfer(1, k % NSUB, (k * 3) % 16, 32'h0F0F_0000 + k, rd);
            xfer(0, (k + 1) % NSUB, (k * 7) % 16, 32'h0, rd);
            check(rd == shadow[(k + 1) % NSUB][(k * 7) % 16], "R7 interleaved read",
                  rd, shadow[(k + 1) % NSUB][(k * 7) % 16]);
        end
        repeat (4) @(negedge hclk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule